// File: doc/BRIEF.md
# Framed Serial Word Aligner

This block turns a recovered serial bit stream into parallel data words. Every word travels as a 12-bit symbol: a start bit of 1, ten data bits sent least-significant bit first, and an end bit of 0. Because the start bit follows the previous symbol's end bit, every symbol boundary carries a 0-to-1 transition. The aligner examines the stream one bit phase at a time and slips its 12-phase bit counter until the framing bits sit where they belong. It declares lock once enough symbols in a row are framed correctly, and it keeps checking framing while locked.

Lock is reported on an active-low indicator. Data is released one word after lock is declared, so that it is valid on the second selected strobe edge of the recovered word clock. The word clock comes from the bit counter. A strobe-select input decides whether the word clock's rising edge or its falling edge falls in the middle of each data word.

An output-enable input gates the data and the word clock without disturbing lock. A power-down input gates every output, clears lock and restarts a settling interval before the search begins again. Pad tri-state is represented by two drive flags: one for the data and word clock, one for the lock indicator.

Top module: `framedWordAligner`

## Requirements
- R1: A symbol is 12 bits in arrival order: start bit 1, data bits 0 to 9 (least-significant first), then end bit 0. While data is valid, `wordData` equals the data field of the most recently completed symbol.
- R2: Lock (`lockN` low) is declared after 8 consecutive correctly framed symbols at one bit phase. After 7 such symbols `lockN` is still high.
- R3: While locked, 3 consecutive framing errors keep lock. The 4th consecutive error drops lock (`lockN` high), and the search then resumes.
- R4: After reset, and after power-down is released, no lock is declared before 2048 word periods (24576 bit clocks) have passed, even when framed symbols are arriving.
- R5: The synchronization symbol is six 1s followed by six 0s in arrival order (data field 0x01F). Once the settling interval is over, lock is declared within 42 word periods of the start of synchronization symbols, whatever the bit phase. From reset release this is within 2048+42 word periods.
- R6: `dataValid` is low on the first selected strobe edge after `lockN` falls and high on the second. `wordData` reads 0 whenever `dataValid` is low.
- R7: While locked, `wordClk` is high for 6 bit clocks and low for 6 bit clocks.
- R8: With `strobeRise`=1, `wordData` changes while `wordClk` is low, so the rising edge falls mid-word. With `strobeRise`=0, the clock is inverted: data changes while `wordClk` is high, and the falling edge is the capture edge.
- R9: With `outEnable` low, `outDrive`, `dataValid`, `wordData` and `wordClk` are 0, while `lockN` keeps its value. When `outEnable` is raised again, data is valid without a new lock search.
- R10: While `powerDown` is high, `lockDrive`, `outDrive`, `dataValid` and `wordClk` are 0 and `lockN` is high. Lock is cleared, and after release the settling interval of R4 restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bitClk | input | 1 | Recovered bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serialIn | input | 1 | Serial data bit, sampled on the rising edge of bitClk |
| powerDown | input | 1 | Power-down request, active high |
| outEnable | input | 1 | Enables the data and word clock outputs |
| strobeRise | input | 1 | 1: rising edge of wordClk is the capture edge; 0: falling edge |
| wordData | output | 10 | Aligned parallel data word |
| wordClk | output | 1 | Recovered word-rate clock |
| lockN | output | 1 | Lock indicator, low when framing lock is held |
| dataValid | output | 1 | Data word is released and driven |
| outDrive | output | 1 | Drive flag for wordData and wordClk |
| lockDrive | output | 1 | Drive flag for lockN |

## Verification
Output disable and framing-loss counting are independent, and both can act within the same word. The bench drops `outEnable` just before the fourth consecutive bad symbol. Lock must then fall because of the framing errors alone, while data and clock stay gated. After the outputs are re-enabled, the bench checks that data stays invalid until a fresh eight-symbol lock and its one-word release, and that `lockN` never left its framing-driven value while the outputs were disabled.

// File: rtl/framedWordAlignerPkg.sv
package framedWordAlignerPkg;
  // Strobes issued by the control to the datapath
  typedef struct packed {
    logic clearAll;  // synchronous clear (power-down)
    logic slip;      // hold the bit counter one cycle: try next phase
    logic loadWord;  // capture the data field into the word register
  } ctrlStrobe_t;
endpackage

// File: rtl/framedWordPath.sv
module framedWordPath
  import framedWordAlignerPkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serialIn,
  input  ctrlStrobe_t       strobe,
  output logic              boundary,
  output logic              frameOk,
  output logic              phaseHigh,
  output logic [DATA_W-1:0] wordReg
);
  localparam int SYM_W  = DATA_W + 2;
  localparam int HALF_W = SYM_W / 2;
  localparam int CNT_W  = $clog2(SYM_W);

  logic [SYM_W-1:0] shiftReg;
  logic [CNT_W-1:0] bitCnt;

  // newest bit enters at the top; bit 0 is the oldest (start position)
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                shiftReg <= '0;
    else if (strobe.clearAll) shiftReg <= '0;
    else                      shiftReg <= {serialIn, shiftReg[SYM_W-1:1]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               bitCnt <= '0;
    else if (strobe.clearAll)                bitCnt <= '0;
    else if (strobe.slip)                    bitCnt <= bitCnt;
    else if (bitCnt == CNT_W'(SYM_W - 1))    bitCnt <= '0;
    else                                     bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                wordReg <= '0;
    else if (strobe.clearAll) wordReg <= '0;
    else if (strobe.loadWord) wordReg <= shiftReg[SYM_W-2:1];
  end

  assign boundary  = (bitCnt == CNT_W'(SYM_W - 1));
  assign frameOk   = shiftReg[0] & ~shiftReg[SYM_W-1];
  assign phaseHigh = (bitCnt >= CNT_W'(HALF_W));

  // R7: phase counter never leaves its 12-state range
  assert_phase_range_R7: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt < CNT_W'(SYM_W));

  // R1: words are only captured on a symbol boundary
  assert_load_on_boundary_R1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadWord |-> boundary);
endmodule

// File: rtl/framedWordCtrl.sv
module framedWordCtrl
  import framedWordAlignerPkg::*;
#(
  parameter int DATA_W       = 10,
  parameter int SETTLE_WORDS = 2048,
  parameter int LOCK_RUN     = 8,
  parameter int LOSS_RUN     = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        powerDown,
  input  logic        boundary,
  input  logic        frameOk,
  output ctrlStrobe_t strobe,
  output logic        locked,
  output logic        released
);
  localparam int SYM_W      = DATA_W + 2;
  localparam int SETTLE_CYC = SETTLE_WORDS * SYM_W;
  localparam int SET_W      = $clog2(SETTLE_CYC + 1);
  localparam int GOOD_W     = $clog2(LOCK_RUN + 1);
  localparam int BAD_W      = $clog2(LOSS_RUN + 1);

  logic [SET_W-1:0]  settleCnt;
  logic              settled;
  logic [GOOD_W-1:0] goodCnt;
  logic [BAD_W-1:0]  badCnt;
  logic              check;

  assign check           = boundary && settled;
  assign strobe.clearAll = powerDown;
  assign strobe.slip     = check && !locked && !frameOk;
  assign strobe.loadWord = boundary && locked;

  // settling interval after reset or power-down release
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
      settled   <= 1'b0;
    end else if (powerDown) begin
      settleCnt <= '0;
      settled   <= 1'b0;
    end else if (!settled) begin
      if (settleCnt == SET_W'(SETTLE_CYC - 1)) settled <= 1'b1;
      settleCnt <= settleCnt + 1'b1;
    end
  end

  // framing search, lock and loss tracking
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      locked   <= 1'b0;
      released <= 1'b0;
      goodCnt  <= '0;
      badCnt   <= '0;
    end else if (powerDown) begin
      locked   <= 1'b0;
      released <= 1'b0;
      goodCnt  <= '0;
      badCnt   <= '0;
    end else if (check) begin
      if (!locked) begin
        if (!frameOk) begin
          goodCnt <= '0;
        end else if (goodCnt == GOOD_W'(LOCK_RUN - 1)) begin
          locked  <= 1'b1;
          goodCnt <= '0;
        end else begin
          goodCnt <= goodCnt + 1'b1;
        end
      end else begin
        if (frameOk) begin
          badCnt   <= '0;
          released <= 1'b1;
        end else if (badCnt == BAD_W'(LOSS_RUN - 1)) begin
          locked   <= 1'b0;
          released <= 1'b0;
          badCnt   <= '0;
        end else begin
          badCnt   <= badCnt + 1'b1;
          released <= 1'b1;
        end
      end
    end
  end

  // R2: lock can only appear right after a correctly framed boundary
  assert_lock_on_good_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(boundary && frameOk));

  // R3 / R10: lock falls only on a framing error or on power-down
  assert_loss_cause_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> ($past(powerDown) || $past(boundary && !frameOk)));

  // R4: no lock during the settling interval
  assert_settle_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    !settled |-> !locked);
endmodule

// File: rtl/framedWordAligner.sv
module framedWordAligner
  import framedWordAlignerPkg::*;
#(
  parameter int DATA_W       = 10,
  parameter int SETTLE_WORDS = 2048,
  parameter int LOCK_RUN     = 8,
  parameter int LOSS_RUN     = 4
) (
  input  logic              bitClk,
  input  logic              rstN,
  input  logic              serialIn,
  input  logic              powerDown,
  input  logic              outEnable,
  input  logic              strobeRise,
  output logic [DATA_W-1:0] wordData,
  output logic              wordClk,
  output logic              lockN,
  output logic              dataValid,
  output logic              outDrive,
  output logic              lockDrive
);
  ctrlStrobe_t       strobe;
  logic              boundary;
  logic              frameOk;
  logic              phaseHigh;
  logic              locked;
  logic              released;
  logic [DATA_W-1:0] wordReg;

  framedWordPath #(.DATA_W(DATA_W)) uPath (
    .clk       (bitClk),
    .rstN      (rstN),
    .serialIn  (serialIn),
    .strobe    (strobe),
    .boundary  (boundary),
    .frameOk   (frameOk),
    .phaseHigh (phaseHigh),
    .wordReg   (wordReg)
  );

  framedWordCtrl #(
    .DATA_W       (DATA_W),
    .SETTLE_WORDS (SETTLE_WORDS),
    .LOCK_RUN     (LOCK_RUN),
    .LOSS_RUN     (LOSS_RUN)
  ) uCtrl (
    .clk       (bitClk),
    .rstN      (rstN),
    .powerDown (powerDown),
    .boundary  (boundary),
    .frameOk   (frameOk),
    .strobe    (strobe),
    .locked    (locked),
    .released  (released)
  );

  // output gating stands in for pad tri-state
  assign outDrive  = !powerDown && outEnable;
  assign lockDrive = !powerDown;
  assign dataValid = outDrive && released;
  assign wordData  = dataValid ? wordReg : '0;
  assign wordClk   = outDrive && (phaseHigh == strobeRise);
  assign lockN     = !(lockDrive && locked);

  // R6: released data always implies an asserted lock indicator
  assert_valid_needs_lock_R6: assert property (@(posedge bitClk) disable iff (!rstN)
    dataValid |-> !lockN);

  // R6: data is never released in the cycle the lock indicator falls
  assert_staged_release_R6: assert property (@(posedge bitClk) disable iff (!rstN)
    $fell(lockN) |-> !dataValid);
endmodule

// File: tb/tb_framedWordAligner.sv
module tb_framedWordAligner;
  localparam int DATA_W       = 10;
  localparam int SYM_W        = 12;
  localparam int SETTLE_WORDS = 2048;
  localparam int LOCK_WIN     = 42;
  localparam logic [9:0] SYNC = 10'h01F;

  logic bitClk = 1'b0;
  logic rstN = 1'b0, serialIn = 1'b0, powerDown = 1'b0;
  logic outEnable = 1'b1, strobeRise = 1'b1;
  logic [DATA_W-1:0] wordData;
  logic wordClk, lockN, dataValid, outDrive, lockDrive;

  framedWordAligner dut (
    .bitClk(bitClk), .rstN(rstN), .serialIn(serialIn), .powerDown(powerDown),
    .outEnable(outEnable), .strobeRise(strobeRise), .wordData(wordData),
    .wordClk(wordClk), .lockN(lockN), .dataValid(dataValid),
    .outDrive(outDrive), .lockDrive(lockDrive)
  );

  always #5 bitClk = ~bitClk;

  int testsRun = 0, testsFailed = 0, cyc = 0;
  int lockFallCyc = 0, lockRiseCnt = 0, edgeAfterLock = 0;
  bit armed = 0, pushOn = 0;
  logic [9:0] expQ[$];

  always @(posedge bitClk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finishRun();
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  // bit 0 goes first on the line
  task automatic sendBits(input logic [11:0] sym);
    for (int i = 0; i < SYM_W; i++) begin
      @(negedge bitClk);
      serialIn = sym[i];
    end
  endtask

  task automatic sendWord(input logic [9:0] d);
    sendBits({1'b0, d, 1'b1});
    if (pushOn) expQ.push_back(d);
  endtask

  task automatic sendBad();
    sendBits(12'h0AA);  // start bit 0: framing error
  endtask

  // control inputs change away from the sampling edge
  task automatic settle1();
    @(posedge bitClk);
    #1;
  endtask

  // monitor: scoreboard, release staging, strobe placement
  logic prevClk = 0, prevLockN = 1, prevValid = 0, selEdge;
  logic [9:0] prevData = '0, expWord;
  always @(negedge bitClk) begin
    selEdge = strobeRise ? (!prevClk && wordClk) : (prevClk && !wordClk);
    if (rstN) begin
      if (prevLockN && !lockN) begin
        lockFallCyc = cyc;
        armed = outEnable;
        edgeAfterLock = 0;
      end
      if (!prevLockN && lockN) lockRiseCnt++;
      if (selEdge && armed) begin
        edgeAfterLock++;
        if (edgeAfterLock == 1) begin
          check(!dataValid, "R6", "valid on 1st strobe edge", dataValid, 0);
        end else begin
          check(dataValid, "R6", "valid on 2nd strobe edge", dataValid, 1);
          armed = 0;
        end
      end
      if (selEdge && expQ.size() > 0) begin
        expWord = expQ.pop_front();
        check(dataValid && wordData == expWord, "R1", "word at capture edge",
              wordData, expWord);
      end
      if (dataValid && prevValid && wordData != prevData)
        check(wordClk == !strobeRise, "R8", "word clock level at data change",
              wordClk, !strobeRise);
    end
    prevClk = wordClk; prevLockN = lockN; prevValid = dataValid; prevData = wordData;
  end

  task automatic measureClk();
    int hi, lo;
    @(negedge bitClk);
    while (wordClk) @(negedge bitClk);
    while (!wordClk) @(negedge bitClk);
    hi = 0;
    while (wordClk) begin hi++; @(negedge bitClk); end
    lo = 0;
    while (!wordClk) begin lo++; @(negedge bitClk); end
    check(hi == 6, "R7", "word clock high time", hi, 6);
    check(lo == 6, "R7", "word clock low time", lo, 6);
  endtask

  task automatic syncUntilLock(input int limit, output int n);
    n = 0;
    while (lockN && n < limit) begin
      sendWord(SYNC);
      n++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge bitClk);
    testsFailed++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    int relCyc, n, startCyc, risesBefore;
    repeat (4) @(negedge bitClk);
    check(lockN == 1, "R4", "lockN in reset", lockN, 1);
    check(dataValid == 0 && wordData == 0, "R6", "data in reset", wordData, 0);

    // initial settle and lock with sync symbols from the start
    settle1(); rstN = 1; relCyc = cyc;
    sendWord(SYNC);
    syncUntilLock(SETTLE_WORDS + LOCK_WIN + 8, n);
    check(!lockN, "R5", "lock after reset", lockN, 0);
    check(lockFallCyc - relCyc >= SETTLE_WORDS * SYM_W, "R4", "no lock while settling",
          lockFallCyc - relCyc, SETTLE_WORDS * SYM_W);
    check(lockFallCyc - relCyc <= (SETTLE_WORDS + LOCK_WIN) * SYM_W, "R5",
          "lock time from reset", lockFallCyc - relCyc, (SETTLE_WORDS + LOCK_WIN) * SYM_W);

    // data words, rising-edge capture, clock duty
    sendWord(SYNC); sendWord(SYNC);
    pushOn = 1;
    fork
      begin
        sendWord(10'h3FF); sendWord(10'h000); sendWord(10'h2A5);
        sendWord(10'h001); sendWord(10'h200); sendWord(10'h155);
      end
      measureClk();
    join
    pushOn = 0;
    sendWord(SYNC);

    // falling-edge capture
    settle1(); strobeRise = 0;
    sendWord(SYNC);
    pushOn = 1;
    sendWord(10'h0F0); sendWord(10'h30C); sendWord(10'h003); sendWord(10'h1C7);
    pushOn = 0;
    sendWord(SYNC);
    settle1(); strobeRise = 1;
    sendWord(SYNC);

    // output disable keeps lock
    risesBefore = lockRiseCnt;
    settle1(); outEnable = 0;
    sendWord(SYNC);
    check(outDrive == 0 && dataValid == 0, "R9", "outputs off when disabled", outDrive, 0);
    check(wordData == 0 && wordClk == 0, "R9", "data/clock low when disabled", wordData, 0);
    check(lockN == 0, "R9", "lock kept when disabled", lockN, 0);
    settle1(); outEnable = 1;
    sendWord(SYNC);
    check(dataValid == 1, "R9", "data back after enable", dataValid, 1);
    check(lockRiseCnt == risesBefore, "R9", "lock never dropped", lockRiseCnt, risesBefore);
    pushOn = 1;
    sendWord(10'h2DB); sendWord(10'h124);
    pushOn = 0;
    sendWord(SYNC);

    // three errors keep lock
    sendBad(); sendBad(); sendBad();
    sendWord(SYNC);
    sendWord(SYNC);
    check(lockN == 0, "R3", "lock kept after 3 errors", lockN, 0);

    // fourth error coincides with output disable
    sendBad(); sendBad(); sendBad();
    settle1(); outEnable = 0;
    sendBad();
    sendWord(SYNC);  // 1st framed symbol after loss
    check(lockN == 1, "R3", "lock lost after 4 errors", lockN, 1);
    check(dataValid == 0 && outDrive == 0, "R9", "outputs off at loss", dataValid, 0);
    settle1(); outEnable = 1;
    check(dataValid == 0, "R6", "no data without lock", dataValid, 0);

    // eight framed symbols are needed
    for (int i = 0; i < 7; i++) sendWord(SYNC);
    check(lockN == 1, "R2", "no lock after 7 framed symbols", lockN, 1);
    sendWord(SYNC);
    check(lockN == 0, "R2", "lock after 8 framed symbols", lockN, 0);
    sendWord(SYNC); sendWord(SYNC);

    // phase search after a bit shift
    for (int i = 0; i < 4; i++) sendBad();
    sendWord(SYNC);
    check(lockN == 1, "R3", "lock lost again", lockN, 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge bitClk);
      serialIn = 1'b0;
    end
    startCyc = cyc;
    syncUntilLock(LOCK_WIN + 6, n);
    check(!lockN, "R5", "relock after phase shift", lockN, 0);
    check(lockFallCyc - startCyc <= LOCK_WIN * SYM_W, "R5", "search time",
          lockFallCyc - startCyc, LOCK_WIN * SYM_W);
    sendWord(SYNC); sendWord(SYNC);
    pushOn = 1;
    sendWord(10'h0AB); sendWord(10'h354);
    pushOn = 0;
    sendWord(SYNC);

    // power-down
    settle1(); powerDown = 1;
    sendWord(SYNC);
    check(lockN == 1 && lockDrive == 0, "R10", "lock off in power-down", lockN, 1);
    check(outDrive == 0 && dataValid == 0 && wordClk == 0, "R10",
          "outputs off in power-down", outDrive, 0);
    sendWord(SYNC);
    settle1(); powerDown = 0; relCyc = cyc;
    syncUntilLock(SETTLE_WORDS + LOCK_WIN + 8, n);
    check(!lockN, "R10", "lock after power-up", lockN, 0);
    check(lockFallCyc - relCyc >= SETTLE_WORDS * SYM_W, "R10", "settle restarted",
          lockFallCyc - relCyc, SETTLE_WORDS * SYM_W);
    check(lockFallCyc - relCyc <= (SETTLE_WORDS + LOCK_WIN) * SYM_W, "R5",
          "lock time from power-up", lockFallCyc - relCyc, (SETTLE_WORDS + LOCK_WIN) * SYM_W);
    sendWord(SYNC); sendWord(SYNC);
    pushOn = 1;
    sendWord(10'h3C3); sendWord(10'h07E);
    pushOn = 0;
    sendWord(SYNC);
    check(expQ.size() == 0, "R1", "all expected words seen", expQ.size(), 0);
    finishRun();
  end
endmodule